// File: doc/BRIEF.md
# Non-Blocking Miss Tracker

This block lets a processor core keep executing while cache-line refills are outstanding. Each miss carries a line address and an access identifier. A miss to a line that is not yet being fetched takes a fill slot, and that slot then issues one fetch request to the bus side. A miss to a line that already holds a fill slot does not start a second fetch. Instead it is parked in a small ordered pend queue, and it is replayed once that line has arrived.

The core is held off through a stall output, but only when the structure a miss needs is full. A new line needs a free fill slot. A repeat line needs a free pend place. The bus side reports a completed refill by naming the fill slot that its fetch request carried. A drain command stalls the core until both structures are empty and then signals completion for one cycle.

Top module: `miss_track`

## Requirements
- R1: After reset, core_stall, fetch_valid, replay_valid and drain_done are all low, and four distinct misses can be taken.
- R2: Up to FILL_N (4) misses to different lines are accepted without raising core_stall, and each produces exactly one fetch carrying its line.
- R3: While all fill slots are occupied, a miss to a new line raises core_stall in the same cycle and is not taken. Once a completed slot has been freed, the same miss is accepted and fetched through that slot.
- R4: A miss whose line equals the line of any occupied fill slot is taken into the pend queue and produces no new fetch.
- R5: When the pend queue holds PEND_N (4) entries, a repeat-line miss raises core_stall. A miss to a new line is still accepted while a fill slot is free.
- R6: After a refill completes for a slot, every pend entry of that line is presented on replay_valid/replay_id/replay_line, one per cycle, in the order the misses arrived. Entries of other lines are not replayed.
- R7: A fill slot becomes free once its refill has completed and its pend entries have been replayed. A later miss to the same line then starts a new fetch.
- R8: Each fill slot issues exactly one fetch, handshaken by fetch_valid and fetch_ready. While fetch_ready is low, fetch_valid, fetch_line and fetch_slot hold steady.
- R9: A one-cycle drain_req holds core_stall high until both the fill slots and the pend queue are empty. It then gives a single-cycle drain_done pulse, and the stall is released.
- R10: A new line takes the lowest-numbered free fill slot (0 to FILL_N-1). fetch_slot carries that number, and fill_done_slot must return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_line | input | LINE_W | Logical line address of the miss |
| miss_id | input | ID_W | Access identifier returned on replay |
| core_stall | output | 1 | Miss not taken / drain in progress |
| fetch_valid | output | 1 | Bus fetch request valid |
| fetch_ready | input | 1 | Bus side accepts the fetch |
| fetch_line | output | LINE_W | Line address to fetch |
| fetch_slot | output | SLOT_W | Fill slot number of the fetch |
| fill_done_valid | input | 1 | A refill has completed |
| fill_done_slot | input | SLOT_W | Slot whose refill completed |
| replay_valid | output | 1 | A pended access is ready for replay |
| replay_id | output | ID_W | Identifier of the replayed access |
| replay_line | output | LINE_W | Line of the replayed access |
| drain_req | input | 1 | Request to empty all tracking state |
| drain_done | output | 1 | Drain complete, one-cycle pulse |

## Verification
Distinct-line patterns are swept from one to four misses. They show that the buffer accepts misses freely below capacity, that it stalls exactly at capacity, and that it reuses the freed slot. Repeat-line patterns are swept from zero to four repeats of one line, and then one beyond. These separate a new fetch from pending, check the replay count and order, and check the stall on a full pend queue. An interleaved two-line pattern with completions returned out of order shows that replays follow the completing line and keep arrival order within it. Back-pressure on the fetch and a drain that starts with fills in flight or with nothing in flight round out the set.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Life cycle of one fill slot
  typedef enum logic [1:0] {
    FE_FREE   = 2'd0,  // unused
    FE_WAIT   = 2'd1,  // allocated, fetch not yet handed to the bus
    FE_BUSY   = 2'd2,  // fetch accepted, refill outstanding
    FE_LANDED = 2'd3   // refill done, replays may still be pending
  } fe_state_e;
endpackage

// File: rtl/mt_fill_table.sv
module mt_fill_table
  import mt_pkg::*;
#(
  parameter int FILL_N = 4,
  parameter int LINE_W = 26,
  localparam int SLOT_W = (FILL_N > 1) ? $clog2(FILL_N) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LINE_W-1:0]              lookup_line,
  input  logic                           alloc_en,
  input  logic                           issue_en,
  input  logic [SLOT_W-1:0]              issue_slot,
  input  logic                           land_en,
  input  logic [SLOT_W-1:0]              land_slot,
  input  logic [FILL_N-1:0]              hold_mask,
  output fe_state_e [FILL_N-1:0]         state_o,
  output logic [FILL_N-1:0][LINE_W-1:0]  line_o,
  output logic [FILL_N-1:0]              match_vec,
  output logic                           free_any,
  output logic [SLOT_W-1:0]              alloc_slot,
  output logic                           wait_any,
  output logic [SLOT_W-1:0]              wait_slot
);

  // Lowest-numbered free slot and lowest-numbered slot awaiting a fetch
  always_comb begin
    free_any   = 1'b0;
    alloc_slot = '0;
    wait_any   = 1'b0;
    wait_slot  = '0;
    for (int i = FILL_N - 1; i >= 0; i--) begin
      if (state_o[i] == FE_FREE) begin
        free_any   = 1'b1;
        alloc_slot = SLOT_W'(i);
      end
      if (state_o[i] == FE_WAIT) begin
        wait_any  = 1'b1;
        wait_slot = SLOT_W'(i);
      end
    end
  end

  for (genvar g = 0; g < FILL_N; g++) begin : g_slot
    fe_state_e          st_q, st_d;
    logic [LINE_W-1:0]  ln_q;
    logic               take;

    assign take         = alloc_en && (alloc_slot == SLOT_W'(g)) && (st_q == FE_FREE);
    assign match_vec[g] = (st_q != FE_FREE) && (ln_q == lookup_line);
    assign state_o[g]   = st_q;
    assign line_o[g]    = ln_q;

    always_comb begin
      st_d = st_q;
      unique case (st_q)
        FE_FREE:   if (take) st_d = FE_WAIT;
        FE_WAIT:   if (issue_en && issue_slot == SLOT_W'(g)) st_d = FE_BUSY;
        FE_BUSY:   if (land_en && land_slot == SLOT_W'(g)) st_d = FE_LANDED;
        FE_LANDED: if (!hold_mask[g]) st_d = FE_FREE;
        default:   st_d = FE_FREE;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FE_FREE;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ln_q <= '0;
      else if (take) ln_q <= lookup_line;
    end
  end

endmodule

// File: rtl/mt_pend_queue.sv
module mt_pend_queue #(
  parameter int PEND_N = 4,
  parameter int FILL_N = 4,
  parameter int ID_W   = 6,
  localparam int SLOT_W = (FILL_N > 1) ? $clog2(FILL_N) : 1,
  localparam int PIDX_W = (PEND_N > 1) ? $clog2(PEND_N) : 1,
  localparam int CNT_W  = $clog2(PEND_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic [SLOT_W-1:0]  push_slot,
  input  logic [ID_W-1:0]    push_id,
  input  logic [FILL_N-1:0]  landed_mask,
  output logic               pop_valid,
  output logic [ID_W-1:0]    pop_id,
  output logic [SLOT_W-1:0]  pop_slot,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_o,
  output logic [FILL_N-1:0]  ref_mask
);

  // Entries 0..count-1 are live, index 0 being the oldest
  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic [PEND_N-1:0][SLOT_W-1:0]  slot_q, slot_d;
  logic [PEND_N-1:0][ID_W-1:0]    id_q, id_d;
  logic [PIDX_W-1:0]              pop_idx;
  logic                           upd;

  // Oldest live entry whose line has landed
  always_comb begin
    pop_valid = 1'b0;
    pop_idx   = '0;
    for (int i = PEND_N - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < cnt_q) && landed_mask[slot_q[i]]) begin
        pop_valid = 1'b1;
        pop_idx   = PIDX_W'(i);
      end
    end
  end

  assign pop_id   = id_q[pop_idx];
  assign pop_slot = slot_q[pop_idx];
  assign count_o  = cnt_q;
  assign full_o   = (cnt_q == CNT_W'(PEND_N));

  always_comb begin
    ref_mask = '0;
    for (int i = 0; i < PEND_N; i++) begin
      if (CNT_W'(i) < cnt_q) ref_mask[slot_q[i]] = 1'b1;
    end
  end

  // Remove the popped entry by shifting younger ones down, then append
  always_comb begin
    slot_d = slot_q;
    id_d   = id_q;
    cnt_d  = cnt_q;
    if (pop_valid) begin
      for (int i = 0; i < PEND_N - 1; i++) begin
        if (PIDX_W'(i) >= pop_idx) begin
          slot_d[i] = slot_q[i+1];
          id_d[i]   = id_q[i+1];
        end
      end
      cnt_d = cnt_d - CNT_W'(1);
    end
    if (push_en) begin
      slot_d[PIDX_W'(cnt_d)] = push_slot;
      id_d[PIDX_W'(cnt_d)]   = push_id;
      cnt_d = cnt_d + CNT_W'(1);
    end
  end

  assign upd = push_en | pop_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      id_q   <= '0;
    end else if (upd) begin
      slot_q <= slot_d;
      id_q   <= id_d;
    end
  end

endmodule

// File: rtl/mt_fetch_port.sv
module mt_fetch_port #(
  parameter int FILL_N = 4,
  parameter int LINE_W = 26,
  localparam int SLOT_W = (FILL_N > 1) ? $clog2(FILL_N) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wait_any,
  input  logic [SLOT_W-1:0]              wait_slot,
  input  logic [FILL_N-1:0][LINE_W-1:0]  line_tab,
  input  logic                           fetch_ready,
  output logic                           fetch_valid,
  output logic [SLOT_W-1:0]              fetch_slot,
  output logic [LINE_W-1:0]              fetch_line,
  output logic                           issue_en
);

  logic              busy_q, busy_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              load;

  // Latch one waiting slot and hold it until the handshake completes
  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    load   = 1'b0;
    if (busy_q) begin
      if (fetch_ready) busy_d = 1'b0;
    end else if (wait_any) begin
      busy_d = 1'b1;
      slot_d = wait_slot;
      load   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (load) slot_q <= slot_d;
  end

  assign fetch_valid = busy_q;
  assign fetch_slot  = slot_q;
  assign fetch_line  = line_tab[slot_q];
  assign issue_en    = busy_q & fetch_ready;

endmodule

// File: rtl/miss_track.sv
module miss_track
  import mt_pkg::*;
#(
  parameter int FILL_N = 4,
  parameter int PEND_N = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 6,
  localparam int SLOT_W = (FILL_N > 1) ? $clog2(FILL_N) : 1,
  localparam int PCNT_W = $clog2(PEND_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [LINE_W-1:0]  miss_line,
  input  logic [ID_W-1:0]    miss_id,
  output logic               core_stall,
  output logic               fetch_valid,
  input  logic               fetch_ready,
  output logic [LINE_W-1:0]  fetch_line,
  output logic [SLOT_W-1:0]  fetch_slot,
  input  logic               fill_done_valid,
  input  logic [SLOT_W-1:0]  fill_done_slot,
  output logic               replay_valid,
  output logic [ID_W-1:0]    replay_id,
  output logic [LINE_W-1:0]  replay_line,
  input  logic               drain_req,
  output logic               drain_done
);

  fe_state_e [FILL_N-1:0]         fill_state;
  logic [FILL_N-1:0][LINE_W-1:0]  fill_lines;
  logic [FILL_N-1:0]              match_vec, landed_mask, ref_mask, hold_mask;
  logic                           free_any, wait_any, issue_en;
  logic [SLOT_W-1:0]              alloc_slot, wait_slot, hit_slot, pop_slot;
  logic                           hit, accept, alloc_en, push_en;
  logic                           pend_full;
  logic [PCNT_W-1:0]              pend_cnt;
  logic                           all_free;
  logic                           drain_q, drain_d;

  // Line lookup against occupied slots
  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int i = FILL_N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    all_free = 1'b1;
    for (int i = 0; i < FILL_N; i++) begin
      if (fill_state[i] != FE_FREE) all_free = 1'b0;
    end
  end

  for (genvar g = 0; g < FILL_N; g++) begin : g_land
    assign landed_mask[g] = (fill_state[g] == FE_LANDED);
  end

  assign core_stall = drain_q | (miss_valid & (hit ? pend_full : ~free_any));
  assign accept     = miss_valid & ~core_stall;
  assign alloc_en   = accept & ~hit;
  assign push_en    = accept & hit;
  assign hold_mask  = ref_mask | (push_en ? (FILL_N'(1) << hit_slot) : '0);

  mt_fill_table #(.FILL_N(FILL_N), .LINE_W(LINE_W)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookup_line (miss_line),
    .alloc_en    (alloc_en),
    .issue_en    (issue_en),
    .issue_slot  (fetch_slot),
    .land_en     (fill_done_valid),
    .land_slot   (fill_done_slot),
    .hold_mask   (hold_mask),
    .state_o     (fill_state),
    .line_o      (fill_lines),
    .match_vec   (match_vec),
    .free_any    (free_any),
    .alloc_slot  (alloc_slot),
    .wait_any    (wait_any),
    .wait_slot   (wait_slot)
  );

  mt_pend_queue #(.PEND_N(PEND_N), .FILL_N(FILL_N), .ID_W(ID_W)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_en),
    .push_slot   (hit_slot),
    .push_id     (miss_id),
    .landed_mask (landed_mask),
    .pop_valid   (replay_valid),
    .pop_id      (replay_id),
    .pop_slot    (pop_slot),
    .count_o     (pend_cnt),
    .full_o      (pend_full),
    .ref_mask    (ref_mask)
  );

  mt_fetch_port #(.FILL_N(FILL_N), .LINE_W(LINE_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_any    (wait_any),
    .wait_slot   (wait_slot),
    .line_tab    (fill_lines),
    .fetch_ready (fetch_ready),
    .fetch_valid (fetch_valid),
    .fetch_slot  (fetch_slot),
    .fetch_line  (fetch_line),
    .issue_en    (issue_en)
  );

  assign replay_line = fill_lines[pop_slot];

  // Drain control
  assign drain_done = drain_q & all_free & (pend_cnt == '0);

  always_comb begin
    drain_d = drain_q;
    if (drain_done)     drain_d = 1'b0;
    else if (drain_req) drain_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drain_q <= 1'b0;
    else        drain_q <= drain_d;
  end

endmodule

// File: rtl/miss_track_chk.sv
module miss_track_chk
  import mt_pkg::*;
#(
  parameter int FILL_N = 4,
  parameter int PEND_N = 4,
  parameter int LINE_W = 26,
  localparam int SLOT_W = (FILL_N > 1) ? $clog2(FILL_N) : 1,
  localparam int PCNT_W = $clog2(PEND_N + 1)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           miss_valid,
  input logic [LINE_W-1:0]              miss_line,
  input logic                           core_stall,
  input logic                           fetch_valid,
  input logic                           fetch_ready,
  input logic [LINE_W-1:0]              fetch_line,
  input logic [SLOT_W-1:0]              fetch_slot,
  input logic                           replay_valid,
  input logic                           drain_done,
  input fe_state_e [FILL_N-1:0]         fill_state,
  input logic [FILL_N-1:0][LINE_W-1:0]  fill_lines,
  input logic [PCNT_W-1:0]              pend_cnt
);

  logic dup, seen, idle, any_landed;
  int   occ_n;

  always_comb begin
    dup = 1'b0; seen = 1'b0; idle = 1'b1; any_landed = 1'b0; occ_n = 0;
    for (int i = 0; i < FILL_N; i++) begin
      if (fill_state[i] != FE_FREE) begin
        occ_n++;
        idle = 1'b0;
        if (fill_lines[i] == miss_line) seen = 1'b1;
        for (int j = i + 1; j < FILL_N; j++) begin
          if (fill_state[j] != FE_FREE && fill_lines[j] == fill_lines[i]) dup = 1'b1;
        end
      end
      if (fill_state[i] == FE_LANDED) any_landed = 1'b1;
    end
  end

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && occ_n == FILL_N && !seen) |-> core_stall);

  assert_unique_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);

  assert_pend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PCNT_W'(PEND_N));

  assert_replay_after_land_R6: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> any_landed);

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_line) && $stable(fetch_slot)));

  assert_single_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> !fetch_valid);

  assert_drain_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> (idle && pend_cnt == '0));

endmodule

bind miss_track miss_track_chk #(.FILL_N(FILL_N), .PEND_N(PEND_N), .LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .miss_line    (miss_line),
  .core_stall   (core_stall),
  .fetch_valid  (fetch_valid),
  .fetch_ready  (fetch_ready),
  .fetch_line   (fetch_line),
  .fetch_slot   (fetch_slot),
  .replay_valid (replay_valid),
  .drain_done   (drain_done),
  .fill_state   (fill_state),
  .fill_lines   (fill_lines),
  .pend_cnt     (pend_cnt)
);

// File: tb/miss_track_tb.sv
module miss_track_tb;
  localparam int LINE_W = 26;
  localparam int ID_W   = 6;
  localparam int SLOT_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              miss_valid;
  logic [LINE_W-1:0] miss_line;
  logic [ID_W-1:0]   miss_id;
  logic              core_stall, fetch_valid, fetch_ready;
  logic [LINE_W-1:0] fetch_line, replay_line;
  logic [SLOT_W-1:0] fetch_slot, fill_done_slot;
  logic              fill_done_valid, replay_valid, drain_req, drain_done;
  logic [ID_W-1:0]   replay_id;

  always #10 clk = ~clk;

  miss_track u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_id(miss_id), .core_stall(core_stall), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_line(fetch_line), .fetch_slot(fetch_slot),
    .fill_done_valid(fill_done_valid), .fill_done_slot(fill_done_slot),
    .replay_valid(replay_valid), .replay_id(replay_id), .replay_line(replay_line),
    .drain_req(drain_req), .drain_done(drain_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Logs gathered from the ports, sampled 8 ns after each falling edge
  int fetch_n, replay_n, drain_n;
  int fetch_ln [64];
  int fetch_sl [64];
  int replay_ids [64];
  int replay_lns [64];

  always @(negedge clk) begin
    #8;
    if (rst_n === 1'b1) begin
      if (fetch_valid && fetch_ready && fetch_n < 64) begin
        fetch_ln[fetch_n] = int'(fetch_line);
        fetch_sl[fetch_n] = int'(fetch_slot);
        fetch_n++;
      end
      if (replay_valid && replay_n < 64) begin
        replay_ids[replay_n] = int'(replay_id);
        replay_lns[replay_n] = int'(replay_line);
        replay_n++;
      end
      if (drain_done) drain_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; miss_valid = 0; miss_line = '0; miss_id = '0; fetch_ready = 1;
    fill_done_valid = 0; fill_done_slot = '0; drain_req = 0;
    step(3);
    rst_n = 1'b1;
    fetch_n = 0; replay_n = 0; drain_n = 0;
  endtask

  // Present one miss, check the stall it sees, then withdraw it
  task automatic miss(input int line, input int id, input bit exp_stall, input string req);
    @(negedge clk);
    miss_valid = 1; miss_line = LINE_W'(line); miss_id = ID_W'(id);
    #5;
    check(core_stall == exp_stall, req, "core_stall on miss", int'(core_stall), int'(exp_stall));
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic fill(input int slot);
    @(negedge clk);
    fill_done_valid = 1; fill_done_slot = SLOT_W'(slot);
    @(negedge clk);
    fill_done_valid = 0;
  endtask

  task automatic drain_pulse();
    @(negedge clk); drain_req = 1;
    @(negedge clk); drain_req = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: quiet after reset
    reset_dut();
    #8;
    check(!core_stall, "R1", "core_stall", int'(core_stall), 0);
    check(!fetch_valid, "R1", "fetch_valid", int'(fetch_valid), 0);
    check(!replay_valid, "R1", "replay_valid", int'(replay_valid), 0);
    check(!drain_done, "R1", "drain_done", int'(drain_done), 0);

    // R2, R3, R10: sweep 1..4 distinct lines
    for (int n = 1; n <= 4; n++) begin
      reset_dut();
      for (int i = 0; i < n; i++) miss(200 + i, i, 0, "R2");
      step(5);
      check(fetch_n == n, "R2", "fetch count", fetch_n, n);
      for (int i = 0; i < n; i++) begin
        check(fetch_ln[i] == 200 + i, "R2", "fetch line", fetch_ln[i], 200 + i);
        check(fetch_sl[i] == i, "R10", "fetch slot", fetch_sl[i], i);
      end
      if (n == 4) begin
        miss(999, 9, 1, "R3");
        step(3);
        check(fetch_n == 4, "R3", "no fetch while full", fetch_n, 4);
        fill(2);
        step(3);
        miss(999, 9, 0, "R3");
        step(5);
        check(fetch_n == 5, "R3", "fetch count after free", fetch_n, 5);
        check(fetch_ln[4] == 999, "R3", "reused line", fetch_ln[4], 999);
        check(fetch_sl[4] == 2, "R10", "reused slot", fetch_sl[4], 2);
      end
    end

    // R4, R5, R6, R7: sweep 0..4 repeats of one line
    for (int k = 0; k <= 4; k++) begin
      reset_dut();
      miss(100 + k, 0, 0, "R4");
      step(4);
      for (int j = 0; j < k; j++) miss(100 + k, k * 8 + j, 0, "R4");
      if (k == 4) begin
        miss(100 + k, 63, 1, "R5");
        miss(300, 1, 0, "R5");
      end
      step(4);
      check(fetch_n == ((k == 4) ? 2 : 1), "R4", "fetches for repeats", fetch_n, (k == 4) ? 2 : 1);
      fill(0);
      step(8);
      check(replay_n == k, "R6", "replay count", replay_n, k);
      for (int j = 0; j < k; j++) begin
        check(replay_ids[j] == k * 8 + j, "R6", "replay order", replay_ids[j], k * 8 + j);
        check(replay_lns[j] == 100 + k, "R6", "replay line", replay_lns[j], 100 + k);
      end
      miss(100 + k, 5, 0, "R7");
      step(5);
      check(fetch_n == ((k == 4) ? 3 : 2), "R7", "refetch after free", fetch_n, (k == 4) ? 3 : 2);
      check(fetch_sl[fetch_n - 1] == 0, "R7", "refetch slot", fetch_sl[fetch_n - 1], 0);
    end

    // R6: two lines interleaved, completions out of order
    reset_dut();
    miss(40, 0, 0, "R6");
    miss(41, 0, 0, "R6");
    step(4);
    miss(40, 1, 0, "R6");
    miss(41, 2, 0, "R6");
    miss(40, 3, 0, "R6");
    miss(41, 4, 0, "R6");
    fill(1);
    step(6);
    check(replay_n == 2, "R6", "replays of second line", replay_n, 2);
    check(replay_ids[0] == 2, "R6", "first replay id", replay_ids[0], 2);
    check(replay_ids[1] == 4, "R6", "second replay id", replay_ids[1], 4);
    fill(0);
    step(6);
    check(replay_n == 4, "R6", "replays total", replay_n, 4);
    check(replay_ids[2] == 1, "R6", "third replay id", replay_ids[2], 1);
    check(replay_ids[3] == 3, "R6", "fourth replay id", replay_ids[3], 3);

    // R8: back-pressure on the fetch
    reset_dut();
    fetch_ready = 0;
    miss(77, 0, 0, "R8");
    step(3); #8;
    check(fetch_valid == 1, "R8", "fetch_valid held", int'(fetch_valid), 1);
    check(fetch_line == 77, "R8", "fetch_line held", int'(fetch_line), 77);
    step(3); #8;
    check(fetch_valid == 1 && fetch_line == 77, "R8", "still held", int'(fetch_line), 77);
    check(fetch_n == 0, "R8", "no handshake yet", fetch_n, 0);
    fetch_ready = 1;
    step(4); #8;
    check(fetch_n == 1, "R8", "single fetch", fetch_n, 1);
    check(fetch_valid == 0, "R8", "fetch_valid dropped", int'(fetch_valid), 0);

    // R9: drain with fills in flight
    reset_dut();
    miss(10, 0, 0, "R9");
    miss(11, 0, 0, "R9");
    step(4);
    miss(10, 5, 0, "R9");
    drain_pulse();
    step(2); #8;
    check(drain_n == 0, "R9", "no early done", drain_n, 0);
    check(core_stall == 1, "R9", "stall while draining", int'(core_stall), 1);
    fill(0);
    step(4);
    check(drain_n == 0, "R9", "done waits for last fill", drain_n, 0);
    fill(1);
    step(6); #8;
    check(drain_n == 1, "R9", "single done pulse", drain_n, 1);
    check(core_stall == 0, "R9", "stall released", int'(core_stall), 0);
    check(replay_n == 1 && replay_ids[0] == 5, "R9", "pended access replayed", replay_n, 1);

    // R9: drain when already empty
    reset_dut();
    drain_pulse();
    step(3);
    check(drain_n == 1, "R9", "done on empty", drain_n, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule